// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shifter

This block steps a single "row select" token across a row of panel gate lines, one line per clock. A start pulse is taken from one of two bidirectional start pins, loaded into the first stage of the scan order on a rising clock edge, and then moves one stage per rising edge. While it sits in a stage, that stage's gate line is asserted. One direction input decides which start pin is the input and which one carries the cascade pulse on to the next device in a chain. It also decides whether the scan runs from line 1 upward or from the last line downward.

The start pulse level is programmable. Two asynchronous override inputs act on the gate lines, and each has its own programmable active level. One forces every line low and the other forces every line high. The force-low override wins when both are active. Neither override touches the shift register, so a scan that is in progress picks up where it would have been once the overrides are released. Each bidirectional start pin appears at the ports as a separate input, output and output-enable signal.

Top module: `gate_scan_shifter`

## Requirements
- R1: A start pulse at its active level on the input start pin is sampled on a rising clock edge. The first line of the scan order is then asserted for exactly the one clock period that follows that edge.
- R2: With `scan_fwd` = 1, the right start pin is the input and the token visits `gate_out[0]`, `gate_out[1]` … `gate_out[N-1]` in turn, one line per rising edge.
- R3: With `scan_fwd` = 0, the left start pin is the input and the token visits `gate_out[N-1]` down to `gate_out[0]`, one line per rising edge.
- R4: With `start_pol` = 1 the start pulse is active-high. With `start_pol` = 0 it is active-low. A pin at the opposite level loads nothing.
- R5: The cascade pin takes its active level on the N-th falling clock edge after the rising edge that sampled the start. It returns to the inactive level on the (N+1)-th falling edge.
- R6: The cascade pulse uses the same active level as `start_pol`. It is driven on the left pin when `scan_fwd` = 1 and on the right pin when `scan_fwd` = 0, and the output enable of the input pin is 0.
- R7: When `force_lo_en` equals `force_lo_lvl`, every gate line is 0 at once, without waiting for a clock edge.
- R8: When `force_hi_en` equals `force_hi_lvl` and the force-low override is not active, every gate line is 1 at once, without waiting for a clock edge.
- R9: When both overrides are active, every gate line is 0.
- R10: The overrides never alter the shift register. On release, the lines show the token position that shifting would have reached, including any clock edges that occurred during the override.
- R11: While reset is asserted, all gate lines are 0 and the cascade pin is driven at its inactive level.
- R12: A second start pulse loaded while an earlier token is still in the chain forms a second token. Both tokens shift independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_fwd | input | 1 | 1: right pin in, order 0..N-1; 0: left pin in, order N-1..0 |
| start_pol | input | 1 | Active level of the start and cascade pulses |
| force_lo_en | input | 1 | Force-all-low override request |
| force_lo_lvl | input | 1 | Active level of `force_lo_en` |
| force_hi_en | input | 1 | Force-all-high override request |
| force_hi_lvl | input | 1 | Active level of `force_hi_en` |
| stp_r_in | input | 1 | Right start pin, input side |
| stp_r_out | output | 1 | Right start pin, driven value |
| stp_r_oe | output | 1 | Right start pin, output enable |
| stp_l_in | input | 1 | Left start pin, input side |
| stp_l_out | output | 1 | Left start pin, driven value |
| stp_l_oe | output | 1 | Left start pin, output enable |
| gate_out | output | N_STAGES | Gate line levels, bit k is line k+1 |

## Verification
A stage flipped in the wrong way shows on `gate_out` in the very next clock period. It appears as a missing, doubled or misplaced line, and it is checked in every period of every sweep. A fault at the end of the chain, or in the falling-edge stage, shows on the cascade pin half a period after the last line is asserted. A register that an override disturbed stays hidden while the override is active. It is exposed in the first period after release, when the lines are compared with the position shifting alone would give.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef enum logic {
    SCAN_REV = 1'b0,
    SCAN_FWD = 1'b1
  } scan_dir_e;

  // A request is active when it equals its programmed level.
  function automatic logic lvl_match(input logic sig, input logic lvl);
    return ~(sig ^ lvl);
  endfunction
endpackage

// File: rtl/gss_rst_sync.sv
module gss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gss_shift_chain.sv
module gss_shift_chain
  import gss_pkg::*;
#(
  parameter int unsigned N_STAGES = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  scan_dir_e           dir,
  input  logic                load_bit,
  output logic [N_STAGES-1:0] chain_q,
  output logic                tail_bit
);
  logic [N_STAGES-1:0] chain_d;

  always_comb begin
    if (dir == SCAN_FWD) chain_d = {chain_q[N_STAGES-2:0], load_bit};
    else                 chain_d = {load_bit, chain_q[N_STAGES-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign tail_bit = (dir == SCAN_FWD) ? chain_q[N_STAGES-1] : chain_q[0];
endmodule

// File: rtl/gss_cascade.sv
module gss_cascade
  import gss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  scan_dir_e dir,
  input  logic      pulse_pol,
  input  logic      tail_bit,
  output logic      r_out,
  output logic      r_oe,
  output logic      l_out,
  output logic      l_oe
);
  logic casc_q;
  logic casc_d;
  logic casc_lvl;

  assign casc_d = tail_bit;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= casc_d;
  end

  assign casc_lvl = pulse_pol ? casc_q : ~casc_q;

  always_comb begin
    if (dir == SCAN_FWD) begin
      l_oe  = 1'b1;
      l_out = casc_lvl;
      r_oe  = 1'b0;
      r_out = 1'b0;
    end else begin
      r_oe  = 1'b1;
      r_out = casc_lvl;
      l_oe  = 1'b0;
      l_out = 1'b0;
    end
  end
endmodule

// File: rtl/gss_line_force.sv
module gss_line_force #(
  parameter int unsigned N_STAGES = 240
) (
  input  logic                force_lo,
  input  logic                force_hi,
  input  logic [N_STAGES-1:0] chain_q,
  output logic [N_STAGES-1:0] lines
);
  for (genvar k = 0; k < N_STAGES; k++) begin : g_line
    always_comb begin
      if (force_lo)      lines[k] = 1'b0;
      else if (force_hi) lines[k] = 1'b1;
      else               lines[k] = chain_q[k];
    end
  end
endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
  import gss_pkg::*;
#(
  parameter int unsigned N_STAGES = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_fwd,
  input  logic                start_pol,
  input  logic                force_lo_en,
  input  logic                force_lo_lvl,
  input  logic                force_hi_en,
  input  logic                force_hi_lvl,
  input  logic                stp_r_in,
  output logic                stp_r_out,
  output logic                stp_r_oe,
  input  logic                stp_l_in,
  output logic                stp_l_out,
  output logic                stp_l_oe,
  output logic [N_STAGES-1:0] gate_out
);
  scan_dir_e           dir;
  logic                rst_sync_n;
  logic                start_pin;
  logic                start_act;
  logic                force_lo;
  logic                force_hi;
  logic                tail_bit;
  logic [N_STAGES-1:0] chain_q;

  assign dir       = scan_dir_e'(scan_fwd);
  assign start_pin = (dir == SCAN_FWD) ? stp_r_in : stp_l_in;
  assign start_act = lvl_match(start_pin, start_pol);
  assign force_lo  = lvl_match(force_lo_en, force_lo_lvl);
  assign force_hi  = lvl_match(force_hi_en, force_hi_lvl);

  gss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gss_shift_chain #(.N_STAGES(N_STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dir      (dir),
    .load_bit (start_act),
    .chain_q  (chain_q),
    .tail_bit (tail_bit)
  );

  gss_cascade u_casc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dir       (dir),
    .pulse_pol (start_pol),
    .tail_bit  (tail_bit),
    .r_out     (stp_r_out),
    .r_oe      (stp_r_oe),
    .l_out     (stp_l_out),
    .l_oe      (stp_l_oe)
  );

  gss_line_force #(.N_STAGES(N_STAGES)) u_force (
    .force_lo (force_lo),
    .force_hi (force_hi),
    .chain_q  (chain_q),
    .lines    (gate_out)
  );
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
  parameter int unsigned N_STAGES = 240
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                scan_fwd,
  input logic                start_pol,
  input logic                stp_r_in,
  input logic                stp_l_in,
  input logic                force_lo_en,
  input logic                force_lo_lvl,
  input logic                force_hi_en,
  input logic                force_hi_lvl,
  input logic                stp_r_oe,
  input logic                stp_l_oe,
  input logic [N_STAGES-1:0] chain_q,
  input logic [N_STAGES-1:0] gate_out
);
  // R2
  fwd_shift_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scan_fwd && $past(scan_fwd)) |->
      (chain_q[N_STAGES-1:1] == $past(chain_q[N_STAGES-2:0])));

  // R3
  rev_shift_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!scan_fwd && !$past(scan_fwd)) |->
      (chain_q[N_STAGES-2:0] == $past(chain_q[N_STAGES-1:1])));

  // R1 R4
  fwd_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scan_fwd |=> (chain_q[0] == $past(stp_r_in == start_pol)));

  // R1 R4
  rev_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !scan_fwd |=> (chain_q[N_STAGES-1] == $past(stp_l_in == start_pol)));

  // R7 R9
  force_lo_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_lo_en == force_lo_lvl) |-> (gate_out == '0));

  // R8
  force_hi_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((force_hi_en == force_hi_lvl) && (force_lo_en != force_lo_lvl)) |->
      (gate_out == '1));

  // R10
  pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((force_hi_en != force_hi_lvl) && (force_lo_en != force_lo_lvl)) |->
      (gate_out == chain_q));

  // R6
  pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stp_l_oe == scan_fwd) && (stp_r_oe == !scan_fwd));
endmodule

bind gate_scan_shifter gss_checker #(.N_STAGES(N_STAGES)) u_gss_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .scan_fwd     (scan_fwd),
  .start_pol    (start_pol),
  .stp_r_in     (stp_r_in),
  .stp_l_in     (stp_l_in),
  .force_lo_en  (force_lo_en),
  .force_lo_lvl (force_lo_lvl),
  .force_hi_en  (force_hi_en),
  .force_hi_lvl (force_hi_lvl),
  .stp_r_oe     (stp_r_oe),
  .stp_l_oe     (stp_l_oe),
  .chain_q      (chain_q),
  .gate_out     (gate_out)
);

// File: tb/gate_scan_shifter_bench.sv
module gate_scan_shifter_bench;
  localparam int unsigned N = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic scan_fwd, start_pol;
  logic force_lo_en, force_lo_lvl, force_hi_en, force_hi_lvl;
  logic stp_r_in, stp_l_in;
  logic stp_r_out, stp_r_oe, stp_l_out, stp_l_oe;
  logic [N-1:0] gate_out;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  logic [N-1:0] m_q;
  logic         m_cas;

  always #10 clk = ~clk;

  gate_scan_shifter #(.N_STAGES(N)) u_gate_scan_shifter (
    .clk(clk), .rst_n(rst_n), .scan_fwd(scan_fwd), .start_pol(start_pol),
    .force_lo_en(force_lo_en), .force_lo_lvl(force_lo_lvl),
    .force_hi_en(force_hi_en), .force_hi_lvl(force_hi_lvl),
    .stp_r_in(stp_r_in), .stp_r_out(stp_r_out), .stp_r_oe(stp_r_oe),
    .stp_l_in(stp_l_in), .stp_l_out(stp_l_out), .stp_l_oe(stp_l_oe),
    .gate_out(gate_out)
  );

  // Reference: the token moves one line per rising edge in the selected order.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= '0;
    else if (scan_fwd) m_q <= {m_q[N-2:0], (stp_r_in == start_pol)};
    else               m_q <= {(stp_l_in == start_pol), m_q[N-1:1]};
  end

  // Reference: the cascade copies the last line of the order on falling edges.
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_cas <= 1'b0;
    else        m_cas <= scan_fwd ? m_q[N-1] : m_q[0];
  end

  function automatic logic [N-1:0] exp_lines();
    if (force_lo_en == force_lo_lvl) return '0;
    if (force_hi_en == force_hi_lvl) return '1;
    return m_q;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_casc(input string req);
    logic lvl;
    lvl = start_pol ? m_cas : ~m_cas;
    if (scan_fwd) check(req, {stp_l_oe, stp_r_oe, stp_l_out}, {1'b1, 1'b0, lvl});
    else          check(req, {stp_r_oe, stp_l_oe, stp_r_out}, {1'b1, 1'b0, lvl});
  endtask

  task automatic idle_overrides();
    force_lo_en = ~force_lo_lvl;
    force_hi_en = ~force_hi_lvl;
  endtask

  task automatic set_start(input logic act);
    logic v;
    v = act ? start_pol : ~start_pol;
    stp_r_in = scan_fwd ? v : ~v;
    stp_l_in = scan_fwd ? ~v : v;
  endtask

  // One period: inputs set 2 ns after a rising edge, lines checked 5 ns after
  // the next rising edge, cascade checked 5 ns after the falling edge.
  task automatic step(input logic start, input string req);
    set_start(start);
    @(posedge clk);
    #5;
    check(req, gate_out, exp_lines());
    #10;
    check_casc("R5 R6");
    #7;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_start(1'b0);
    repeat (2) @(posedge clk);
    #5;
    // R11
    check("R11", gate_out, '0);
    check_casc("R11");
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    scan_fwd = 1'b1; start_pol = 1'b1;
    force_lo_lvl = 1'b1; force_hi_lvl = 1'b1;
    idle_overrides();
    set_start(1'b0);

    // R1 R2 R3 R4 R5 R6: single token, every direction and start level.
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        scan_fwd = d[0]; start_pol = p[0];
        do_reset();
        step(1'b1, d ? "R1 R2 R4" : "R1 R3 R4");
        for (int c = 0; c < N + 3; c++) step(1'b0, d ? "R2" : "R3");
      end
    end

    // R12: two tokens three lines apart in both directions.
    for (int d = 0; d < 2; d++) begin
      scan_fwd = d[0]; start_pol = 1'b0;
      do_reset();
      step(1'b1, "R12");
      step(1'b0, "R12");
      step(1'b0, "R12");
      step(1'b1, "R12");
      for (int c = 0; c < N + 2; c++) step(1'b0, "R12");
    end

    // R7 R8 R9 R10: every level-select combination, asynchronous response.
    for (int lp = 0; lp < 2; lp++) begin
      for (int hp = 0; hp < 2; hp++) begin
        scan_fwd = lp[0] ^ hp[0]; start_pol = 1'b1;
        force_lo_lvl = lp[0]; force_hi_lvl = hp[0];
        idle_overrides();
        do_reset();
        step(1'b1, "R1");
        step(1'b0, "R2 R3");
        #3;
        force_lo_en = force_lo_lvl; #1;
        check("R7", gate_out, '0);
        force_lo_en = ~force_lo_lvl; #1;
        check("R10", gate_out, m_q);
        force_hi_en = force_hi_lvl; #1;
        check("R8", gate_out, '1);
        force_lo_en = force_lo_lvl; #1;
        check("R9", gate_out, '0);
        force_hi_en = ~force_hi_lvl; force_lo_en = ~force_lo_lvl; #1;
        check("R10", gate_out, m_q);
        @(posedge clk); #2;
        // Override held across rising edges: shifting continues underneath.
        force_hi_en = force_hi_lvl;
        step(1'b0, "R8");
        step(1'b0, "R8");
        force_hi_en = ~force_hi_lvl;
        force_lo_en = force_lo_lvl;
        step(1'b0, "R7");
        step(1'b0, "R7");
        force_lo_en = ~force_lo_lvl;
        for (int c = 0; c < N; c++) step(1'b0, "R10");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule